// File: doc/BRIEF.md
# Ancillary Data Insertion Scheduler

The block sits in a 10-bit video word path. Each word carries timing reference sequences (TRS), and a line number arrives with it. A host loads packet bytes into a local buffer through a simple write port. On up to two programmed lines in each frame, the block replaces video words with the buffered bytes, each formatted to a full 10-bit word. The splice starts either in horizontal blanking right after the end-of-active-video TRS (EAV) or right after the start-of-active-video TRS (SAV). In the second case the block overwrites picture words.

Insertion mode has to be enabled through two enable inputs and a 2-bit mode field. When it is enabled, a warm-up counter runs for a fixed number of cycles before the ready flag rises. The buffer accepts host writes only while that flag is high. The output is registered, so every word leaves one cycle after it enters, whether it was spliced or passed through.

Top module: `anc_insert_sched`

## Requirements
- R1: Insertion mode is on only while `fifo_en_i` and `proc_en_i` are both 1 and `mode_i` equals 2'b10. Otherwise no word is replaced and `ready_o` stays 0. After reset `vid_o` is 0 and `ready_o` is 0.
- R2: `ready_o` rises after exactly WARMUP (default 2200) clock edges of continuous insertion mode. Leaving the mode clears it on the next edge and restarts the count.
- R3: A host write (`host_we_i`=1) while `ready_o` is 0 leaves the buffer unchanged.
- R4: The spliced words are buffer entries 0, 1, 2, … in order, one per cycle.
- R5: The number of spliced words is `word_cnt_i` clamped to DEPTH (default 1024). A count of 0 splices nothing.
- R6: A line matches when `line_num_i` equals a nonzero `line_a_i` or `line_b_i`. A register holding 0 never matches. Matching lines receive the splice in every frame.
- R7: With `after_sav_i`=0, splicing begins on the word right after the EAV's fourth word. A TRS is 3FFh, 000h, 000h, XYZ, and EAV has XYZ bit 6 = 1.
- R8: With `after_sav_i`=1, splicing begins on the word right after the SAV's fourth word (XYZ bit 6 = 0). Active video words there are overwritten.
- R9: A 3FFh input word ends any splice in progress. TRS words always reach the output unchanged.
- R10: A spliced word is {~p, p, d}: d is the 8-bit entry and p is the XOR of its bits.
- R11: `vid_o` equals the word presented on `vid_i` one clock earlier, or that word's spliced replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | Buffer enable |
| proc_en_i | input | 1 | Processing enable |
| mode_i | input | 2 | Buffer mode; 2'b10 selects insertion |
| after_sav_i | input | 1 | Splice point: 0 after EAV, 1 after SAV |
| word_cnt_i | input | 11 | Number of buffered words to splice |
| line_a_i | input | 11 | First target line, 0 = unused |
| line_b_i | input | 11 | Second target line, 0 = unused |
| line_num_i | input | 11 | Line number of the current words |
| host_we_i | input | 1 | Host buffer write strobe |
| host_addr_i | input | 10 | Host buffer address |
| host_data_i | input | 8 | Host buffer data |
| vid_i | input | 10 | Incoming video word |
| vid_o | output | 10 | Outgoing video word, one cycle later |
| ready_o | output | 1 | Warm-up complete, host writes accepted |

## Verification
The bench builds the block with its default parameters: a 1024-entry buffer and the full 2200-cycle warm-up. This makes the exact ready edge, the clamp at the full buffer depth (a 1100-word active region with a count of 2047) and a completely host-filled buffer all directly checkable. The modest line lengths cover truncation by the SAV sequence and by the next line's EAV. Random lines then mix target and non-target line numbers, both splice points, and counts from zero past the region lengths.

// File: rtl/anc_pkg.sv
package anc_pkg;
  localparam logic [9:0] TRS_HI      = 10'h3FF;
  localparam logic [9:0] TRS_LO      = 10'h000;
  localparam int         XYZ_H_BIT   = 6;
  localparam logic [1:0] MODE_INSERT = 2'b10;
endpackage

// File: rtl/anc_trs_detect.sv
module anc_trs_detect
  import anc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [9:0] word_i,
  output logic       hit_o,
  output logic       eav_o
);
  logic [9:0] h0_q, h1_q, h2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h0_q <= '0;
      h1_q <= '0;
      h2_q <= '0;
    end else begin
      h0_q <= word_i;
      h1_q <= h0_q;
      h2_q <= h1_q;
    end
  end

  // word_i is the XYZ word when the three before it form the header
  assign hit_o = (h2_q == TRS_HI) && (h1_q == TRS_LO) && (h0_q == TRS_LO);
  assign eav_o = word_i[XYZ_H_BIT];
endmodule

// File: rtl/anc_warmup.sv
module anc_warmup #(
  parameter int unsigned CYCLES = 2200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] TOP = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q != TOP)   cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == TOP);

  a_r2_clear_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ready_o);
endmodule

// File: rtl/anc_word_fmt.sv
module anc_word_fmt (
  input  logic [7:0] d_i,
  output logic [9:0] w_o
);
  logic par;
  assign par = ^d_i;
  assign w_o = {~par, par, d_i};
endmodule

// File: rtl/anc_insert_sched.sv
module anc_insert_sched
  import anc_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned WARMUP = 2200,
  parameter int unsigned LINE_W = 11,
  parameter int unsigned CNT_W  = 11,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              proc_en_i,
  input  logic [1:0]        mode_i,
  input  logic              after_sav_i,
  input  logic [CNT_W-1:0]  word_cnt_i,
  input  logic [LINE_W-1:0] line_a_i,
  input  logic [LINE_W-1:0] line_b_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              host_we_i,
  input  logic [AW-1:0]     host_addr_i,
  input  logic [7:0]        host_data_i,
  input  logic [9:0]        vid_i,
  output logic [9:0]        vid_o,
  output logic              ready_o
);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic          mode_on, ready;
  logic          trs_hit, trs_eav, line_hit, start, ins_now;
  logic [PW-1:0] lim_c, lim_q, rd_q;
  logic          active_q;
  logic [7:0]    rd_byte;
  logic [9:0]    fmt_w;
  logic [7:0]    mem [DEPTH];

  assign mode_on = fifo_en_i && proc_en_i && (mode_i == MODE_INSERT);

  anc_warmup #(.CYCLES(WARMUP)) u_warm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mode_on),
    .ready_o(ready)
  );

  anc_trs_detect u_trs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .word_i(vid_i),
    .hit_o (trs_hit),
    .eav_o (trs_eav)
  );

  always_ff @(posedge clk_i)
    if (host_we_i && ready) mem[host_addr_i] <= host_data_i;

  assign lim_c = (int'(word_cnt_i) > int'(DEPTH)) ? DEPTH_P : PW'(word_cnt_i);

  assign line_hit = ((line_a_i != '0) && (line_num_i == line_a_i)) ||
                    ((line_b_i != '0) && (line_num_i == line_b_i));

  // EAV arms when after_sav_i=0, SAV arms when after_sav_i=1
  assign start = trs_hit && (trs_eav != after_sav_i) && line_hit &&
                 mode_on && ready && (lim_c != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= '0;
      lim_q    <= '0;
    end else if (!mode_on || !ready) begin
      active_q <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      rd_q     <= '0;
      lim_q    <= lim_c;
    end else if (active_q) begin
      if (vid_i == TRS_HI) begin
        active_q <= 1'b0;
      end else begin
        rd_q <= rd_q + 1'b1;
        if (rd_q + 1'b1 == lim_q) active_q <= 1'b0;
      end
    end
  end

  assign ins_now = active_q && mode_on && ready && (vid_i != TRS_HI);
  assign rd_byte = mem[rd_q[AW-1:0]];

  anc_word_fmt u_fmt (
    .d_i(rd_byte),
    .w_o(fmt_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vid_o <= '0;
    else         vid_o <= ins_now ? fmt_w : vid_i;
  end

  assign ready_o = ready;

  a_r9_trs_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_i == TRS_HI) |=> (vid_o == TRS_HI));

  a_r5_within_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (rd_q < lim_q) && (lim_q <= DEPTH_P));

  a_r10_fmt_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_now |=> (vid_o[9] != vid_o[8]) && (vid_o[8] == ^vid_o[7:0]));

  a_r1_idle_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_on |=> (vid_o == $past(vid_i)));
endmodule

// File: tb/sim_anc_insert_sched.sv
`timescale 1ns/1ps
module sim_anc_insert_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_en = 1'b0, proc_en = 1'b0, sel = 1'b0, hwe = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [10:0] cnt = 11'd16, la = 11'd10, lb = 11'd20, line_num = '0;
  logic [9:0]  haddr = '0, vin = 10'h040, vout;
  logic [7:0]  hdata = '0;
  logic        ready;

  int n_chk = 0, n_fail = 0, lerr = 0;
  bit done = 0, pend = 0, mdl_ready = 0;
  logic [9:0] exp_q, l_act, l_exp;
  logic [7:0] mdl [1024];

  always #5 clk = ~clk;

  anc_insert_sched u0 (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .proc_en_i(proc_en),
    .mode_i(mode), .after_sav_i(sel), .word_cnt_i(cnt), .line_a_i(la),
    .line_b_i(lb), .line_num_i(line_num), .host_we_i(hwe), .host_addr_i(haddr),
    .host_data_i(hdata), .vid_i(vin), .vid_o(vout), .ready_o(ready)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R10: {~p, p, d}
  function automatic logic [9:0] bfmt(logic [7:0] d);
    logic p;
    p = ^d;
    return {~p, p, d};
  endfunction

  function automatic logic [9:0] rword();
    return 10'($urandom_range(4, 1019));
  endfunction

  task automatic drive(logic [9:0] w, logic [9:0] e);
    @(negedge clk);
    if (pend && vout !== exp_q) begin
      if (lerr == 0) begin l_act = vout; l_exp = exp_q; end
      lerr++;
    end
    vin = w; exp_q = e; pend = 1;
  endtask

  task automatic idle(int n, string req);
    lerr = 0;
    for (int i = 0; i < n; i++) drive(10'h040, 10'h040);
    chk(lerr == 0, req, l_act, l_exp);
  endtask

  task automatic host_wr(int a, logic [7:0] d);
    hwe = 1'b1; haddr = 10'(a); hdata = d;
    drive(10'h040, 10'h040);
    if (mdl_ready) mdl[a] = d;
    hwe = 1'b0;
  endtask

  task automatic trs(logic [9:0] xyz);
    drive(10'h3FF, 10'h3FF); drive(10'h000, 10'h000);
    drive(10'h000, 10'h000); drive(xyz, xyz);
  endtask

  task automatic send_line(int ln, int blank, int act, string req);
    int n;
    bit hit;
    logic [9:0] w;
    n = (int'(cnt) > 1024) ? 1024 : int'(cnt);
    hit = mdl_ready && ln != 0 && (ln == int'(la) || ln == int'(lb)) && n != 0;
    line_num = 11'(ln);
    lerr = 0;
    trs(10'h274);  // EAV, bit 6 = 1
    for (int k = 0; k < blank; k++) begin
      w = rword();
      drive(w, (hit && !sel && k < n) ? bfmt(mdl[k]) : w);
    end
    trs(10'h2AC);  // SAV, bit 6 = 0
    for (int k = 0; k < act + 2; k++) begin
      w = (k >= act) ? 10'h040 : rword();
      drive(w, (hit && sel && k < n) ? bfmt(mdl[k]) : w);
    end
    chk(lerr == 0, req, l_act, l_exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(vout == 10'h000, "R1 reset vid_o", vout, 0);
    chk(ready == 1'b0, "R1 reset ready", ready, 0);
    rst_n = 1'b1;

    // wrong mode field
    fifo_en = 1; proc_en = 1; mode = 2'b01;
    idle(2300, "R1 R11 passthrough");
    chk(ready == 1'b0, "R1 mode 01", ready, 0);
    send_line(10, 40, 60, "R1 no splice");
    // processing enable low
    mode = 2'b10; proc_en = 0;
    idle(2300, "R1");
    chk(ready == 1'b0, "R1 proc_en low", ready, 0);

    // R2 exact warm-up edge
    proc_en = 1;
    idle(2199, "R2");
    chk(ready == 1'b0, "R2 before", ready, 0);
    idle(1, "R2");
    chk(ready == 1'b1, "R2 at edge", ready, 1);
    mdl_ready = 1;

    for (int a = 0; a < 1024; a++) host_wr(a, 8'($urandom));

    cnt = 11'd16; sel = 0;
    send_line(9, 60, 80, "R6 non-target");
    send_line(10, 60, 80, "R7 R4 R10 line A");
    send_line(11, 60, 80, "R6 non-target");
    send_line(20, 60, 80, "R6 line B");
    send_line(10, 60, 80, "R6 second frame A");
    send_line(20, 60, 80, "R6 second frame B");
    lb = 11'd0;
    send_line(0, 60, 80, "R6 zero register");
    lb = 11'd20;

    sel = 1;
    send_line(10, 60, 80, "R8 overwrite active");

    sel = 0; cnt = 11'd200;
    send_line(20, 50, 80, "R9 stop at SAV");
    sel = 1; cnt = 11'd300;
    send_line(10, 50, 100, "R9 spill tail");
    send_line(0, 50, 60, "R9 next EAV intact");

    cnt = 11'd2047;
    send_line(10, 40, 1100, "R5 clamp depth");
    cnt = 11'd0;
    send_line(10, 40, 80, "R5 zero count");
    cnt = 11'd1;
    send_line(20, 40, 80, "R5 single word");

    // R3: writes during warm-up are dropped
    fifo_en = 0;
    idle(1, "R2");
    chk(ready == 1'b0, "R2 clear", ready, 0);
    mdl_ready = 0;
    fifo_en = 1;
    for (int a = 0; a < 4; a++) host_wr(a, ~mdl[a]);
    idle(2195, "R3");
    chk(ready == 1'b0, "R3 still warming", ready, 0);
    idle(1, "R3");
    chk(ready == 1'b1, "R2 ready again", ready, 1);
    mdl_ready = 1;
    sel = 0; cnt = 11'd8;
    send_line(10, 40, 60, "R3 buffer unchanged");

    for (int i = 0; i < 24; i++) begin
      int pick;
      pick = $urandom_range(0, 3);
      sel = 1'($urandom_range(0, 1));
      cnt = 11'($urandom_range(0, 150));
      send_line(pick == 0 ? 10 : pick == 1 ? 20 : pick == 2 ? 0 : $urandom_range(21, 30),
                $urandom_range(20, 120), $urandom_range(20, 150), "R4 R7 R8 R9 random");
    end
    send_line(0, 30, 30, "R9 final");
    idle(2, "R11");

    done = 1;
    summary();
    $finish;
  end
endmodule